// File: doc/BRIEF.md
# Prioritized Interrupt Delivery Arbiter

This block keeps a vector of thirteen asynchronous interrupt requests waiting for the core. In each cycle it picks at most one of them to hand over. The pick follows a fixed priority order. Each source is gated by its own rule, built from the core's current enable bits, the hypervisor-mode bit and a few partition-control inputs. The winner is reported as a one-cycle strobe that carries an encoded cause. A summary flag shows whether any request is still waiting.

Requests arrive as single-cycle set pulses, one line per source. Delivery clears the pending bit of most sources, like an edge-triggered request. The external and critical-external sources stay pending after delivery, like a level request. Their owners must withdraw them by other means; inside this block, only reset does it. The decrementer clears on delivery only when a configuration input asks for it. Exception entry, vector selection and state save are handled downstream.

Top module: `irq_deliver_arb`

## Requirements
- R1: After reset no request is pending, `take_o` is 0 and `pend_any_o` is 0.
- R2: Cause codes are: 0 system reset, 1 machine check, 2 hypervisor decrementer, 3 external, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable-interval timer, 9 decrementer, 10 doorbell, 11 performance monitor, 12 thermal. `set_i[k]` requests cause k. Among eligible pending requests, the lowest code wins. A pulse on `set_i` at clock edge N makes the request pending after N. It can be delivered, with `take_o` high, after edge N+1.
- R3: Causes 0 and 1 are eligible whenever pending, whatever the enable inputs are. Their pending bits clear on delivery.
- R4: Cause 2 is eligible only when `hdec_en_i` is 1 and either `ext_en_i` is 1 or `hv_mode_i` is 0. It clears on delivery.
- R5: Cause 3 is eligible when `ext_en_i` is 1. It is also eligible when `hv_present_i` is 1, `hv_mode_i` is 0 and `ext_os_route_i` is 0. It stays pending after delivery.
- R6: Cause 4 is eligible only when `crit_en_i` is 1. It stays pending after delivery.
- R7: Causes 5 to 12 are eligible only when `ext_en_i` is 1. Causes 5 to 8 and 10 to 12 clear on delivery.
- R8: Cause 9 clears on delivery only when `decr_clr_i` is 1. Otherwise it stays pending.
- R9: When a set pulse and a delivery clear hit the same source at the same edge, the source stays pending.
- R10: At most one delivery happens per cycle. When no pending request is eligible, `take_o` stays 0 and the pending state changes only by new set pulses.
- R11: `pend_any_o` is 1 exactly when at least one request is pending after the latest edge, delivery clears included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_i | input | 13 | Per-source set pulses, bit k = cause k |
| ext_en_i | input | 1 | External-class enable from machine state |
| crit_en_i | input | 1 | Critical-class enable |
| hv_mode_i | input | 1 | Core is running in hypervisor mode |
| hv_present_i | input | 1 | Hypervisor support exists |
| ext_os_route_i | input | 1 | Partition control: external requests are routed to the guest OS |
| hdec_en_i | input | 1 | Hypervisor decrementer delivery enable |
| decr_clr_i | input | 1 | Decrementer clears on delivery |
| take_o | output | 1 | One-cycle delivery strobe |
| take_cause_o | output | 4 | Encoded cause of the delivery |
| pend_any_o | output | 1 | Some request is still pending |

## Verification
The assertions check several rules on every cycle:
- the picker grants at most one source;
- a pending reset or machine check is always delivered next;
- delivering a level-like source leaves it pending;
- a cause from 5 to 12 is never delivered without the external enable;
- a set pulse always lands in the pending state;
- an idle cycle only adds the new set pulses.

The bench's scenarios cover what needs a full sequence:
- the priority order across many pending requests;
- each gating rule as the enables change;
- the decrementer's two clear modes;
- a set pulse landing at the same edge as a delivery of that source.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSRC    = 13;
  localparam int CAUSE_W = $clog2(NSRC);

  typedef enum logic [CAUSE_W-1:0] {
    CS_RESET = 4'd0,  CS_MCHK = 4'd1,  CS_HDEC = 4'd2,  CS_EXT  = 4'd3,
    CS_CRIT  = 4'd4,  CS_WDOG = 4'd5,  CS_CDBL = 4'd6,  CS_FIT  = 4'd7,
    CS_PIT   = 4'd8,  CS_DECR = 4'd9,  CS_DBL  = 4'd10, CS_PERF = 4'd11,
    CS_THRM  = 4'd12
  } cause_e;

  typedef struct packed {
    logic ext_en;
    logic crit_en;
    logic hv_mode;
    logic hv_present;
    logic ext_os_route;
    logic hdec_en;
    logic decr_clr;
  } gate_ctrl_t;

  // Sources allowed to be taken under the current machine state.
  function automatic logic [NSRC-1:0] allow_mask(input gate_ctrl_t c);
    logic [NSRC-1:0] m;
    m = {NSRC{c.ext_en}};
    m[CS_RESET] = 1'b1;
    m[CS_MCHK]  = 1'b1;
    m[CS_HDEC]  = c.hdec_en & (c.ext_en | ~c.hv_mode);
    m[CS_EXT]   = c.ext_en | (c.hv_present & ~c.hv_mode & ~c.ext_os_route);
    m[CS_CRIT]  = c.crit_en;
    return m;
  endfunction

  // Sources whose pending bit drops when they are delivered.
  function automatic logic [NSRC-1:0] drop_mask(input gate_ctrl_t c);
    logic [NSRC-1:0] m;
    m = {NSRC{1'b1}};
    m[CS_EXT]  = 1'b0;
    m[CS_CRIT] = 1'b0;
    m[CS_DECR] = c.decr_clr;
    return m;
  endfunction

  function automatic logic [CAUSE_W-1:0] onehot_index(input logic [NSRC-1:0] oh);
    logic [CAUSE_W-1:0] idx;
    idx = '0;
    for (int k = 0; k < NSRC; k++)
      if (oh[k]) idx = idx | CAUSE_W'(k);
    return idx;
  endfunction
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_arb_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  gate_ctrl_t      ctrl_i,
  output logic [NSRC-1:0] elig_o,
  output logic [NSRC-1:0] drop_o
);
  always_comb begin
    elig_o = pend_i & allow_mask(ctrl_i);
    drop_o = drop_mask(ctrl_i);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 13
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic [N:0] above;   // above[k]: some request with index below k
  assign above[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_chain
    assign grant_o[k]  = req_i[k] & ~above[k];
    assign above[k+1]  = above[k] | req_i[k];
  end

  assign any_o = above[N];

  always_comb begin
    assert_single_grant_R10: assert ($onehot0(grant_o));
  end
endmodule

// File: rtl/irq_deliver_arb.sv
module irq_deliver_arb
  import irq_arb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     set_i,
  input  logic                ext_en_i,
  input  logic                crit_en_i,
  input  logic                hv_mode_i,
  input  logic                hv_present_i,
  input  logic                ext_os_route_i,
  input  logic                hdec_en_i,
  input  logic                decr_clr_i,
  output logic                take_o,
  output logic [CAUSE_W-1:0]  take_cause_o,
  output logic                pend_any_o
);
  gate_ctrl_t       ctrl;
  logic [NSRC-1:0]  pending_q;
  logic [NSRC-1:0]  elig;
  logic [NSRC-1:0]  drop;
  logic [NSRC-1:0]  grant;
  logic             any_elig;
  logic [NSRC-1:0]  taken_clear;

  assign ctrl = '{ext_en: ext_en_i, crit_en: crit_en_i, hv_mode: hv_mode_i,
                  hv_present: hv_present_i, ext_os_route: ext_os_route_i,
                  hdec_en: hdec_en_i, decr_clr: decr_clr_i};

  irq_gate u_gate (
    .pend_i (pending_q),
    .ctrl_i (ctrl),
    .elig_o (elig),
    .drop_o (drop)
  );

  irq_pick #(.N(NSRC)) u_pick (
    .req_i   (elig),
    .grant_o (grant),
    .any_o   (any_elig)
  );

  assign taken_clear = grant & drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q    <= '0;
      take_o       <= 1'b0;
      take_cause_o <= '0;
    end else begin
      pending_q    <= (pending_q & ~taken_clear) | set_i;  // set wins (R9)
      take_o       <= any_elig;
      take_cause_o <= any_elig ? onehot_index(grant) : take_cause_o;
    end
  end

  assign pend_any_o = |pending_q;

  assert_top_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q[CS_RESET] |=> (take_o && take_cause_o == CS_RESET));

  assert_mchk_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q[CS_MCHK] && !pending_q[CS_RESET]) |=> (take_o && take_cause_o == CS_MCHK));

  assert_level_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && (take_cause_o == CS_EXT || take_cause_o == CS_CRIT)) |-> pending_q[take_cause_o]);

  assert_ext_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_cause_o >= CS_WDOG) |-> $past(ext_en_i));

  assert_set_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pending_q & $past(set_i)) == $past(set_i)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_elig |=> (!take_o && pending_q == $past(pending_q | set_i)));
endmodule

// File: tb/irq_deliver_arb_test.sv
`timescale 1ns/1ps
module irq_deliver_arb_test;
  localparam int N = 13;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] set_i;
  logic ext_en, crit_en, hv_mode, hv_present, os_route, hdec_en, decr_clr;
  logic         take_o;
  logic [3:0]   take_cause_o;
  logic         pend_any_o;

  int errors = 0;
  int checks = 0;
  int mp[N];          // reference pending state, one integer per source
  bit done = 0;

  always #5 clk = ~clk;

  irq_deliver_arb uut (
    .clk(clk), .rst_n(rst_n), .set_i(set_i),
    .ext_en_i(ext_en), .crit_en_i(crit_en), .hv_mode_i(hv_mode),
    .hv_present_i(hv_present), .ext_os_route_i(os_route),
    .hdec_en_i(hdec_en), .decr_clr_i(decr_clr),
    .take_o(take_o), .take_cause_o(take_cause_o), .pend_any_o(pend_any_o)
  );

  function automatic bit allowed(int k);
    if (k <= 1) return 1;
    if (k == 2) return hdec_en && (ext_en || !hv_mode);
    if (k == 3) return ext_en || (hv_present && !hv_mode && !os_route);
    if (k == 4) return crit_en;
    return ext_en;
  endfunction

  function automatic bit drops(int k);
    if (k == 3 || k == 4) return 0;
    if (k == 9) return decr_clr;
    return 1;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] s, input string tag);
    int w = -1;
    int any = 0;
    set_i = s;
    for (int k = 0; k < N; k++)
      if (w < 0 && mp[k] != 0 && allowed(k)) w = k;
    if (w >= 0 && drops(w)) mp[w] = 0;
    for (int k = 0; k < N; k++) if (s[k]) mp[k] = 1;
    for (int k = 0; k < N; k++) if (mp[k] != 0) any = 1;
    @(posedge clk);
    @(negedge clk);
    check(tag, take_o, (w >= 0) ? 1 : 0, "take");
    if (w >= 0) check(tag, take_cause_o, w, "cause");
    check({tag, "/R11"}, pend_any_o, any, "pend_any");
    set_i = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_i = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < N; k++) mp[k] = 0;
    check("R1", take_o, 0, "take after reset");
    check("R1", pend_any_o, 0, "pend_any after reset");
  endtask

  task automatic all_on();
    ext_en = 1; crit_en = 1; hv_mode = 0; hv_present = 0;
    os_route = 1; hdec_en = 1; decr_clr = 1;
  endtask

  initial begin
    all_on();
    rst_n = 1'b0;
    set_i = '0;
    @(negedge clk);
    do_reset();

    // Each source alone, everything enabled
    for (int i = 0; i < N; i++) begin
      string t;
      t = (i <= 1) ? "R3" : (i == 2) ? "R4" : (i == 3) ? "R5" :
          (i == 4) ? "R6" : (i == 9) ? "R8" : "R7";
      do_reset();
      step(N'(1) << i, {t, "/R2"});
      step('0, t);
      step('0, t);
    end

    // Priority sweep across all clearing sources
    do_reset();
    step(13'h1FE7, "R2");
    for (int i = 0; i < 12; i++) step('0, "R2");

    // Level sources: external blocks below it, then critical repeats
    do_reset();
    step(13'h1FFF, "R2");
    for (int i = 0; i < 5; i++) step('0, "R5");
    ext_en = 0;
    for (int i = 0; i < 3; i++) step('0, "R6");
    crit_en = 0;
    step('0, "R10");
    step('0, "R10");

    // Gating with enables off and hypervisor mode on
    do_reset();
    all_on();
    ext_en = 0; crit_en = 0; hv_mode = 1;
    step(13'h1FE4, "R10");
    step('0, "R4");
    step('0, "R10");
    hv_mode = 0;
    step('0, "R4");
    step('0, "R7");
    ext_en = 1;
    for (int i = 0; i < 9; i++) step('0, "R7");

    // External through the hypervisor route
    do_reset();
    all_on();
    ext_en = 0; hv_present = 1; hv_mode = 0; os_route = 1;
    step(13'h0008, "R5");
    step('0, "R5");
    os_route = 0;
    step('0, "R5");
    step('0, "R5");
    hv_mode = 1;
    step('0, "R5");

    // Decrementer without clear-on-delivery
    do_reset();
    all_on();
    decr_clr = 0;
    step(13'h0200, "R8");
    step('0, "R8");
    step('0, "R8");
    decr_clr = 1;
    step('0, "R8");
    step('0, "R8");

    // Set and delivery clear on the same source at one edge
    do_reset();
    all_on();
    ext_en = 0;
    step(13'h0020, "R9");
    ext_en = 1;
    step(13'h0020, "R9");
    step('0, "R9");
    step('0, "R9");

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule